// File: doc/BRIEF.md
# Set-Associative Key-Value Lookup Cache

This block caches 256-bit values under 256-bit keys. The number of ways per set is a parameter and may be 2 or 4. A requester offers a key on a one-at-a-time request port, either as a read or as a write carrying a new value. The controller raises `busy` while it handles the request. It answers with a one-cycle response that carries a hit flag and the value. The low `IDX_W` bits of the key select a set, and the remaining upper bits are kept as the tag.

Reads that miss fetch the line from a backing store over a read request/response handshake. A new line goes into the lowest-numbered empty way of the set. When the set is full, the least recently used way is replaced. The cache is write-back, so each way carries a dirty flag. A dirty victim is first sent to the backing store over a separate write handshake, and the refill starts only after that write completes. A clean victim is dropped without any backing-store traffic. Two free-running counters record hits and misses, so the hit ratio can be measured. The set count is small by default so that a bench can force conflicts.

Top module: `kv_cache_ctrl`

## Requirements
- R1: The set index is `key[IDX_W-1:0]` and the tag is `key[KEY_W-1:IDX_W]`. A lookup hits only when a valid way in that set holds a tag equal to the whole tag, down to the most significant key bit.
- R2: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. On a hit, `resp_valid` is 1 during the cycle that follows the next rising edge, with `resp_hit`=1. For a read, `resp_value` holds the stored value. For a write, it holds the written value.
- R3: `busy` is 1 from the accepting edge until the edge that raises `resp_valid`, and it is 0 while `resp_valid` is 1. A `req_valid` offered while `busy` is 1 is ignored: it produces no response and leaves the counters unchanged.
- R4: A read miss issues `mem_rd_valid` with `mem_rd_key` equal to the request key. The response follows the edge where `mem_rd_done` is seen, with `resp_hit`=0 and `resp_value` equal to `mem_rd_value`. When the victim is empty or clean, no backing-store write is issued.
- R5: On a miss, the new line goes into the lowest-numbered invalid way of the set. If every way is valid, the way that has gone longest without a hit or fill is replaced. Every hit and every fill counts as a use.
- R6: A victim that is valid and dirty is written back first. `mem_wr_key` is the victim's full key ({tag, set}) and `mem_wr_value` is its value. The read request is issued only after `mem_wr_done` has been seen.
- R7: A write hit replaces the stored value and marks the way dirty. A write miss allocates a way (after any write-back) with the new value, marks it dirty and issues no backing-store read.
- R8: `mem_rd_valid` and `mem_wr_valid` are never 1 together. Each stays 1, with its key and value stable, until its done pulse is seen.
- R9: `hit_count` increases by one for each response with `resp_hit`=1, and `miss_count` increases by one for each response with `resp_hit`=0.
- R10: After reset, `busy`, `resp_valid`, both memory requests and both counters are 0, and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_key | input | KEY_W | Lookup key |
| req_wdata | input | VAL_W | Value for a write request |
| busy | output | 1 | Request in progress; new requests are ignored |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was a hit |
| resp_value | output | VAL_W | Value returned or written |
| mem_wr_valid | output | 1 | Write-back request to the backing store |
| mem_wr_key | output | KEY_W | Key of the line being written back |
| mem_wr_value | output | VAL_W | Value of the line being written back |
| mem_wr_done | input | 1 | Write-back completion pulse |
| mem_rd_valid | output | 1 | Refill request to the backing store |
| mem_rd_key | output | KEY_W | Key to fetch |
| mem_rd_done | input | 1 | Refill completion pulse; `mem_rd_value` is valid with it |
| mem_rd_value | input | VAL_W | Refill value |
| hit_count | output | CNT_W | Number of hit responses |
| miss_count | output | CNT_W | Number of miss responses |

## Verification
A corrupted tag or valid flag shows up on the very next lookup of that set as a wrong `resp_hit`, or as a refill where none was expected. A broken dirty flag stays hidden until that line is evicted: it then appears as a missing or extra write-back, or as stale data read back later. Wrong LRU ordering appears only when a full set misses, because the wrong key then comes back as a miss. For this reason, the bench runs a long mixed sequence over a few sets with more tags than ways, and checks every response against a reference model.

// File: rtl/kv_cache_pkg.sv
// Shared types for the key-value cache controller.
// Assumes: only the controller FSM uses the state encoding.
package kv_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_EVICT  = 2'd2,
        ST_REFILL = 2'd3
    } kv_state_e;
endpackage

// File: rtl/kv_way_store.sv
// Per-way line storage: valid, dirty, tag and value for every set.
// Gives combinational read-out and tag match for one set, and has one write port.
// Assumes: the caller never writes two ways in the same cycle.
module kv_way_store #(
    parameter int TAG_W = 252,
    parameter int VAL_W = 256,
    parameter int IDX_W = 4,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_set,
    input  logic [TAG_W-1:0]              rd_tag,
    output logic [WAYS-1:0]               hit_vec,
    output logic [WAYS-1:0]               valid_vec,
    output logic [WAYS-1:0]               dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]    tag_vec,
    output logic [WAYS-1:0][VAL_W-1:0]    val_vec,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [VAL_W-1:0]              wr_val,
    input  logic                          wr_dirty
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  drt_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic [VAL_W-1:0] val_q [SETS];
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Flag bits: cleared by reset, set on each fill of this way.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (sel) begin
                vld_q[wr_set] <= 1'b1;
                drt_q[wr_set] <= wr_dirty;
            end
        end

        // Tag and value payload; needs no reset because the valid flag guards it.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_set] <= wr_tag;
                val_q[wr_set] <= wr_val;
            end
        end

        assign valid_vec[w] = vld_q[rd_set];
        assign dirty_vec[w] = drt_q[rd_set];
        assign tag_vec[w]   = tag_q[rd_set];
        assign val_vec[w]   = val_q[rd_set];
        assign hit_vec[w]   = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
    end

    // A tag may live in at most one way of a set.
    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/kv_lru.sv
// Replacement-order tracker, one entry per set.
// With 2 ways it keeps one bit per set naming the LRU way.
// With more ways it keeps an age rank per way: 0 is the newest, WAYS-1 the oldest.
// Assumes: the set being touched is the set being read.
module kv_lru #(
    parameter int IDX_W = 4,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] lru_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);
    localparam int SETS = 1 << IDX_W;

    if (WAYS == 2) begin : g_bit
        logic [SETS-1:0] lru_q;

        // The bit names the older way; a touch points it at the other one.
        always_ff @(posedge clk) begin
            if (!rst_n)        lru_q <= '1;
            else if (touch_en) lru_q[rd_set] <= ~touch_way[0];
        end

        assign lru_way = WAY_W'(lru_q[rd_set]);
    end else begin : g_rank
        logic [WAYS-1:0][WAY_W-1:0] rank_q [SETS];
        logic [WAYS-1:0]            seen;

        // Age ranks: the touched way becomes 0; ways that were newer grow one older.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        rank_q[s][w] <= WAY_W'(w);
            end else if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        rank_q[rd_set][w] <= '0;
                    else if (rank_q[rd_set][w] < rank_q[rd_set][touch_way])
                        rank_q[rd_set][w] <= rank_q[rd_set][w] + 1'b1;
                end
            end
        end

        // Find the oldest way and record which ranks are present.
        always_comb begin
            lru_way = '0;
            seen    = '0;
            for (int w = 0; w < WAYS; w++) begin
                seen[rank_q[rd_set][w]] = 1'b1;
                if (rank_q[rd_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
            end
        end

        // The ranks of a set must stay a permutation.
        assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seen) == WAYS);
    end
endmodule

// File: rtl/kv_victim.sv
// Victim choice on a miss: the lowest-numbered invalid way if there is one,
// otherwise the way that the LRU tracker names.
// Assumes: purely combinational; the inputs come from the set being looked up.
module kv_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] lru_way,
    output logic [WAY_W-1:0] vict_way,
    output logic             has_empty
);
    // Priority search, scanning downward so that the lowest empty way wins.
    always_comb begin
        vict_way  = lru_way;
        has_empty = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                vict_way  = WAY_W'(w);
                has_empty = 1'b1;
            end
        end
    end
endmodule

// File: rtl/kv_cache_ctrl.sv
// Write-back, set-associative key-value cache controller with LRU replacement.
// It handles one request at a time. Hits answer one cycle after acceptance.
// Misses fill an empty way, or else write back a dirty LRU victim before refilling.
// Assumes: the backing store raises each done pulse only while the matching
// request is held high.
module kv_cache_ctrl
    import kv_cache_pkg::*;
#(
    parameter int KEY_W = 256,
    parameter int VAL_W = 256,
    parameter int IDX_W = 4,
    parameter int WAYS  = 2,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [KEY_W-1:0] req_key,
    input  logic [VAL_W-1:0] req_wdata,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [VAL_W-1:0] resp_value,
    output logic             mem_wr_valid,
    output logic [KEY_W-1:0] mem_wr_key,
    output logic [VAL_W-1:0] mem_wr_value,
    input  logic             mem_wr_done,
    output logic             mem_rd_valid,
    output logic [KEY_W-1:0] mem_rd_key,
    input  logic             mem_rd_done,
    input  logic [VAL_W-1:0] mem_rd_value,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int TAG_W = KEY_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    kv_state_e        state_q, state_d;
    logic [KEY_W-1:0] key_q;
    logic             write_q;
    logic [VAL_W-1:0] wdata_q;
    logic [WAY_W-1:0] vict_q;
    logic             resp_v_q, resp_h_q;
    logic [VAL_W-1:0] resp_val_q;
    logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q;

    logic [IDX_W-1:0]           lk_set;
    logic [TAG_W-1:0]           lk_tag;
    logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0] tag_vec;
    logic [WAYS-1:0][VAL_W-1:0] val_vec;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way, lru_way, vict_way;
    logic                       has_empty;

    logic             st_wr_en, st_wr_dirty;
    logic [WAY_W-1:0] st_wr_way;
    logic [VAL_W-1:0] st_wr_val;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic             do_resp, resp_h_d, latch_vict;
    logic [VAL_W-1:0] resp_val_d;

    assign lk_set = key_q[IDX_W-1:0];
    assign lk_tag = key_q[KEY_W-1:IDX_W];

    kv_way_store #(.TAG_W(TAG_W), .VAL_W(VAL_W), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_set(lk_set), .rd_tag(lk_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .tag_vec(tag_vec), .val_vec(val_vec),
        .wr_en(st_wr_en), .wr_set(lk_set), .wr_way(st_wr_way), .wr_tag(lk_tag),
        .wr_val(st_wr_val), .wr_dirty(st_wr_dirty)
    );

    kv_lru #(.IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) lru_i (
        .clk(clk), .rst_n(rst_n), .rd_set(lk_set), .lru_way(lru_way),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    kv_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
        .valid_vec(valid_vec), .lru_way(lru_way), .vict_way(vict_way), .has_empty(has_empty)
    );

    // Encode the matching way from the one-hot hit vector.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Next state, store writes, LRU touches and the response contents.
    always_comb begin
        state_d     = state_q;
        st_wr_en    = 1'b0;
        st_wr_way   = vict_q;
        st_wr_val   = wdata_q;
        st_wr_dirty = 1'b1;
        touch_en    = 1'b0;
        touch_way   = vict_q;
        do_resp     = 1'b0;
        resp_h_d    = 1'b0;
        resp_val_d  = wdata_q;
        latch_vict  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit) begin
                    touch_en  = 1'b1;
                    touch_way = hit_way;
                    st_wr_en  = write_q;
                    st_wr_way = hit_way;
                    do_resp   = 1'b1;
                    resp_h_d  = 1'b1;
                    if (!write_q) resp_val_d = val_vec[hit_way];
                    state_d   = ST_IDLE;
                end else begin
                    latch_vict = 1'b1;
                    if (!has_empty && valid_vec[vict_way] && dirty_vec[vict_way]) begin
                        state_d = ST_EVICT;
                    end else if (write_q) begin
                        st_wr_en  = 1'b1;
                        st_wr_way = vict_way;
                        touch_en  = 1'b1;
                        touch_way = vict_way;
                        do_resp   = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_wr_done) begin
                    if (write_q) begin
                        st_wr_en = 1'b1;
                        touch_en = 1'b1;
                        do_resp  = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                if (mem_rd_done) begin
                    st_wr_en    = 1'b1;
                    st_wr_val   = mem_rd_value;
                    st_wr_dirty = 1'b0;
                    touch_en    = 1'b1;
                    do_resp     = 1'b1;
                    resp_val_d  = mem_rd_value;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller registers: state, captured request, victim, response and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            key_q      <= '0;
            write_q    <= 1'b0;
            wdata_q    <= '0;
            vict_q     <= '0;
            resp_v_q   <= 1'b0;
            resp_h_q   <= 1'b0;
            resp_val_q <= '0;
            hit_cnt_q  <= '0;
            miss_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            resp_v_q <= do_resp;
            if (state_q == ST_IDLE && req_valid) begin
                key_q   <= req_key;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (latch_vict) vict_q <= vict_way;
            if (do_resp) begin
                resp_h_q   <= resp_h_d;
                resp_val_q <= resp_val_d;
                if (resp_h_d) hit_cnt_q  <= hit_cnt_q + 1'b1;
                else          miss_cnt_q <= miss_cnt_q + 1'b1;
            end
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign resp_valid   = resp_v_q;
    assign resp_hit     = resp_h_q;
    assign resp_value   = resp_val_q;
    assign mem_wr_valid = (state_q == ST_EVICT);
    assign mem_wr_key   = {tag_vec[vict_q], lk_set};
    assign mem_wr_value = val_vec[vict_q];
    assign mem_rd_valid = (state_q == ST_REFILL);
    assign mem_rd_key   = key_q;
    assign hit_count    = hit_cnt_q;
    assign miss_count   = miss_cnt_q;

    // Handshake and response properties.
    assert_no_dual_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_valid && mem_rd_valid));
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_key)));
    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_done) |=> (mem_wr_valid && $stable(mem_wr_key) && $stable(mem_wr_value)));
    assert_resp_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy);
    assert_busy_ends_in_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> resp_valid);
    assert_resp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    assert_hit_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + 1'b1));
    assert_miss_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (miss_count == $past(miss_count) + 1'b1));
endmodule

// File: tb/kv_cache_ctrl_tb.sv
// Bench for kv_cache_ctrl using 4 ways and 4 sets. A reference model, written
// from the requirements, predicts each response and each backing-store transfer.
module kv_cache_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KW  = 256;
    localparam int IW  = 2;
    localparam int NW  = 4;
    localparam int NS  = 1 << IW;
    localparam int TW  = KW - IW;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [KW-1:0] req_key = '0, req_wdata = '0;
    logic busy, resp_valid, resp_hit;
    logic [KW-1:0] resp_value;
    logic mem_wr_valid, mem_rd_valid;
    logic [KW-1:0] mem_wr_key, mem_wr_value, mem_rd_key;
    logic mem_wr_done = 1'b0, mem_rd_done = 1'b0;
    logic [KW-1:0] mem_rd_value = '0;
    logic [31:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kv_cache_ctrl #(.KEY_W(KW), .VAL_W(KW), .IDX_W(IW), .WAYS(NW), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_key(req_key), .req_wdata(req_wdata), .busy(busy), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_value(resp_value), .mem_wr_valid(mem_wr_valid),
        .mem_wr_key(mem_wr_key), .mem_wr_value(mem_wr_value), .mem_wr_done(mem_wr_done),
        .mem_rd_valid(mem_rd_valid), .mem_rd_key(mem_rd_key), .mem_rd_done(mem_rd_done),
        .mem_rd_value(mem_rd_value), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Reference model state.
    bit            mv   [NS][NW];
    bit            md   [NS][NW];
    logic [TW-1:0] mt   [NS][NW];
    logic [KW-1:0] mdat [NS][NW];
    int            mr   [NS][NW];
    logic [KW-1:0] bstore [logic [KW-1:0]];
    int exp_hits = 0, exp_misses = 0;

    function automatic logic [KW-1:0] dflt(input logic [KW-1:0] k);
        return {k[127:0], k[255:128]} ^ {4{64'h5A0F_C3E1_9D27_B46B}};
    endfunction

    function automatic logic [KW-1:0] mk_key(input int t, input int s);
        logic [KW-1:0] k;
        k = {4{64'(t) * 64'h9E37_79B9_7F4A_7C15}};
        k[IW-1:0] = IW'(s);
        return k;
    endfunction

    function automatic logic [KW-1:0] store_val(input logic [KW-1:0] k);
        if (bstore.exists(k)) return bstore[k];
        return dflt(k);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model_touch(input int s, input int w);
        int r = mr[s][w];
        for (int i = 0; i < NW; i++) if (mr[s][i] < r) mr[s][i]++;
        mr[s][w] = 0;
    endtask

    // Issue one request, serve the backing store, and compare against the model.
    task automatic do_req(input bit wr, input logic [KW-1:0] key, input logic [KW-1:0] wd,
                          input bit spam, input string tg);
        int s, hw, v, n, wc, rc;
        bit exp_hit, exp_wb, exp_rd, seen_wb, seen_rd, wb_done, order_bad, got;
        logic [KW-1:0] exp_val, wb_key, wb_val, sk_wb, sv_wb, sk_rd, rv;
        logic [TW-1:0] t;
        s = int'(key[IW-1:0]);
        t = key[KW-1:IW];
        hw = -1;
        for (int w = 0; w < NW; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
        exp_hit = (hw >= 0); exp_wb = 0; exp_rd = 0; wb_key = '0; wb_val = '0;
        if (exp_hit) begin
            exp_val = wr ? wd : mdat[s][hw];
            if (wr) begin mdat[s][hw] = wd; md[s][hw] = 1; end
            model_touch(s, hw);
            exp_hits++;
        end else begin
            v = -1;
            for (int w = NW - 1; w >= 0; w--) if (!mv[s][w]) v = w;
            if (v < 0) for (int w = 0; w < NW; w++) if (mr[s][w] == NW - 1) v = w;
            if (mv[s][v] && md[s][v]) begin
                exp_wb = 1;
                wb_key = {mt[s][v], IW'(s)};
                wb_val = mdat[s][v];
                bstore[wb_key] = wb_val;
            end
            if (wr) exp_val = wd;
            else begin exp_rd = 1; exp_val = store_val(key); end
            mv[s][v] = 1; md[s][v] = wr; mt[s][v] = t; mdat[s][v] = exp_val;
            model_touch(s, v);
            exp_misses++;
        end
        @(negedge clk);
        req_valid = 1; req_write = wr; req_key = key; req_wdata = wd;
        @(posedge clk);
        n = 0; wc = 0; rc = 0; seen_wb = 0; seen_rd = 0; wb_done = 0; order_bad = 0; got = 0;
        sk_wb = '0; sv_wb = '0; sk_rd = '0; rv = '0;
        while (!got && n < 60) begin
            @(negedge clk);
            n++;
            mem_wr_done = 0;
            mem_rd_done = 0;
            if (n == 1) begin
                req_valid = 0;
                chk(busy === 1'b1, "R3 busy after accept", KW'(busy), KW'(1));
                if (spam) begin
                    req_valid = 1; req_write = 1; req_key = ~key; req_wdata = ~wd;
                end
            end
            if (resp_valid) begin
                got = 1; req_valid = 0; rv = resp_value;
                chk(resp_hit === exp_hit, tg, KW'(resp_hit), KW'(exp_hit));
                chk(rv === exp_val, exp_hit ? "R2 value" : (wr ? "R7 value" : "R4 value"), rv, exp_val);
                if (exp_hit) chk(n == 2, "R2 hit latency", KW'(n), KW'(2));
            end else begin
                if (mem_wr_valid) begin
                    if (!seen_wb) begin seen_wb = 1; sk_wb = mem_wr_key; sv_wb = mem_wr_value; end
                    wc++;
                    if (wc == LAT) begin mem_wr_done = 1; wb_done = 1; end
                end
                if (mem_rd_valid) begin
                    if (!seen_rd) begin
                        seen_rd = 1; sk_rd = mem_rd_key;
                        if (exp_wb && !wb_done) order_bad = 1;
                    end
                    rc++;
                    if (rc == LAT) begin mem_rd_value = store_val(sk_rd); mem_rd_done = 1; end
                end
            end
        end
        req_valid = 0;
        chk(got, "R3 response arrived", KW'(got), KW'(1));
        chk(seen_wb == exp_wb, "R6 write-back issued", KW'(seen_wb), KW'(exp_wb));
        if (exp_wb && seen_wb) begin
            chk(sk_wb === wb_key, "R6 write-back key", sk_wb, wb_key);
            chk(sv_wb === wb_val, "R6 write-back value", sv_wb, wb_val);
            chk(!order_bad, "R6 refill after write-back", KW'(order_bad), KW'(0));
        end
        chk(seen_rd == exp_rd, wr ? "R7 no refill on write" : "R4 refill issued", KW'(seen_rd), KW'(exp_rd));
        if (exp_rd && seen_rd) chk(sk_rd === key, "R4 refill key", sk_rd, key);
        @(negedge clk);
        chk(resp_valid === 1'b0 && busy === 1'b0, "R3 idle after response", KW'({resp_valid, busy}), KW'(0));
        chk(hit_count == 32'(exp_hits), "R9 hit count", KW'(hit_count), KW'(exp_hits));
        chk(miss_count == 32'(exp_misses), "R9 miss count", KW'(miss_count), KW'(exp_misses));
    endtask

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [KW-1:0] ka, kb;
        int lf;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; mdat[s][w] = '0; mr[s][w] = w;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: state after reset.
        chk(busy === 0 && resp_valid === 0, "R10 busy/resp idle", KW'({busy, resp_valid}), KW'(0));
        chk(mem_wr_valid === 0 && mem_rd_valid === 0, "R10 no memory request", KW'({mem_wr_valid, mem_rd_valid}), KW'(0));
        chk(hit_count == 0 && miss_count == 0, "R10 counters clear", KW'({hit_count, miss_count}), KW'(0));

        // R10/R4: first reads miss into empty ways; R2: a repeated read hits.
        do_req(0, mk_key(1, 0), '0, 0, "R10 first lookup misses");
        do_req(0, mk_key(1, 0), '0, 0, "R2 repeat hits");
        // R5: fill set 0, then reorder its uses.
        for (int t = 2; t <= 4; t++) do_req(0, mk_key(t, 0), '0, 0, "R5 fill empty way");
        do_req(0, mk_key(1, 0), '0, 0, "R5 hit refresh");
        do_req(0, mk_key(3, 0), '0, 0, "R5 hit refresh");
        // R5: tag 2 is now the oldest, so tag 5 replaces it cleanly (R6: no write-back).
        do_req(0, mk_key(5, 0), '0, 0, "R5 full-set miss");
        do_req(0, mk_key(1, 0), '0, 0, "R5 survivor hits");
        do_req(0, mk_key(3, 0), '0, 0, "R5 survivor hits");
        do_req(0, mk_key(2, 0), '0, 0, "R5 LRU way was evicted");
        // R7: a write hit marks the line dirty; R6: evicting it writes it back.
        do_req(1, mk_key(5, 0), {8{32'hFEED_0005}}, 0, "R7 write hit");
        do_req(0, mk_key(6, 0), '0, 0, "R6 miss");
        do_req(0, mk_key(7, 0), '0, 0, "R6 miss");
        do_req(0, mk_key(8, 0), '0, 0, "R6 miss");
        do_req(0, mk_key(9, 0), '0, 0, "R6 miss");
        do_req(0, mk_key(5, 0), '0, 0, "R6 written-back value returns");
        // R7: a write miss allocates without a refill.
        do_req(1, mk_key(20, 1), {8{32'h1234_ABCD}}, 0, "R7 write miss");
        do_req(0, mk_key(20, 1), '0, 0, "R7 allocated line hits");
        // R1: tags differing only in the top key bit are distinct.
        ka = mk_key(30, 2);
        kb = ka ^ (KW'(1) << (KW - 1));
        do_req(0, ka, '0, 0, "R1 miss");
        do_req(0, kb, '0, 0, "R1 MSB-only difference misses");
        do_req(0, ka, '0, 0, "R1 original still hits");
        // R3: requests offered while busy are ignored.
        do_req(0, mk_key(40, 3), '0, 1, "R3 miss with busy traffic");
        do_req(0, mk_key(40, 3), '0, 1, "R3 hit with busy traffic");
        do_req(0, ~mk_key(40, 3), '0, 0, "R3 ignored key was not stored");
        // Mixed sweep over all sets, with more tags than ways.
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
            do_req(((lf >> 3) & 7) < 3, mk_key(100 + ((lf >> 8) % 7 + 7) % 7, (lf >> 16) & 3),
                   {8{32'(lf) ^ 32'(i)}}, ((lf >> 20) & 15) == 0, "R1 sweep hit flag");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule